// File: doc/BRIEF.md
# Oversampled Manchester Line Receiver with Word Deframer

This block takes a single Manchester-coded serial line, sampled by a local clock that runs at roughly eight times the sender's bit rate. It recovers the bit stream as a value plus a one-cycle strobe, then finds word boundaries and delivers each 16-bit word in parallel with a one-cycle valid pulse. It is meant for a remote sensor link where a sender repeats words, each one led by a run of zero bits and a single one bit.

Bit recovery locks onto the transition in the middle of each bit cell. A small counter restarts on every edge that arrives late enough to be a mid-cell edge, and the bit is read shortly after that edge. This lets the sender's bit period drift well away from eight clocks. If the line goes quiet, the receiver drops whatever it was assembling. It then relocks on the first edge it sees.

Top module: `mcr_rx`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `bit_stb` and `word_vld` are 0 and `word_data` is 0. The idle line level is high.
- R2: Encoding: in each bit cell the line carries the inverse of the bit in the first half and the bit itself in the second half, so every cell has a mid-cell edge. After reset or loss, the receiver takes the first edge it sees as a mid-cell edge.
- R3: Each received bit produces exactly one one-cycle `bit_stb` pulse, with `bit_data` equal to the bit. Two strobes never fall on consecutive cycles, and there are no strobes while the line is idle.
- R4: A 1 bit starts a word only if at least 18 consecutive 0 bits were decoded just before it. A 1 bit that follows only 17 zeros is treated as ordinary data and starts nothing.
- R5: The 16 bits after an accepted start bit form the word, most significant bit first: the first bit received lands in `word_data[15]`.
- R6: `word_vld` is high for exactly one cycle, in the cycle after the strobe of the 16th data bit. `word_data` changes only in that cycle and holds its value otherwise.
- R7: Bit periods of 7, 8 and 12 clocks decode correctly. An edge counts as mid-cell only when it arrives 7 to 13 clocks after the previous accepted mid-cell edge.
- R8: If no accepted mid-cell edge arrives within 13 clocks of the previous one, the bit is lost. A partly assembled word is then dropped, the zero count restarts from 0, and the receiver waits for a new start bit.
- R9: The zero count restarts after every delivered word. Zero bits inside a word's data never count toward the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, about 8x the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Asynchronous Manchester serial line |
| bit_data | output | 1 | Recovered bit value, meaningful when `bit_stb` is high |
| bit_stb | output | 1 | One-cycle strobe for each recovered bit |
| word_data | output | 16 | Last assembled word |
| word_vld | output | 1 | One-cycle pulse when `word_data` is loaded |

## Verification
Words are sent with zero runs of 31, exactly 18 and 17 bits. This separates a start-bit threshold that is off by one from a correct one. A word whose data is all zeros is followed by a start bit after only two zeros, which shows whether data zeros leak into the zero count. Frames at bit periods of 7, 12 and 10 clocks test the acceptance window at both ends. A word cut off by an idle line, and a zero run split by a long idle, confirm that a loss discards both the partial word and the partial zero count. Every recovered bit is also compared in order against the bit that was sent.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

    // one recovered bit: strobe plus value
    typedef struct packed {
        logic stb;
        logic val;
    } rxbit_t;

    // framing state of the deframer
    typedef enum logic {
        FR_SEEK    = 1'b0,
        FR_COLLECT = 1'b1
    } fr_state_e;

    // default timing constants, in oversample clocks
    localparam int unsigned GAP_MIN_DEF    = 6;   // counter value at which a mid edge is accepted
    localparam int unsigned GAP_MAX_DEF    = 12;  // counter value at which the bit is declared lost
    localparam int unsigned SAMPLE_DLY_DEF = 2;   // clocks from mid edge to sampling
    localparam int unsigned ZERO_MIN_DEF   = 18;  // zeros needed before a start bit
    localparam int unsigned WORD_W_DEF     = 16;

endpackage

// File: rtl/mcr_sync.sv
module mcr_sync #(
    parameter bit IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl,
    output logic edge_o
);
    // two synchronizer flops followed by one history flop
    logic [2:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= {3{IDLE_LVL}};
        end else begin
            sh <= {sh[1:0], din};
        end
    end

    assign lvl    = sh[1];
    assign edge_o = sh[1] ^ sh[2];

endmodule

// File: rtl/mcr_phase.sv
module mcr_phase
    import mcr_pkg::*;
#(
    parameter int unsigned GAP_MIN    = GAP_MIN_DEF,
    parameter int unsigned GAP_MAX    = GAP_MAX_DEF,
    parameter int unsigned SAMPLE_DLY = SAMPLE_DLY_DEF
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   lvl,
    input  logic   edge_i,
    output rxbit_t bit_o,
    output logic   lost_o
);
    localparam int unsigned CW = $clog2(GAP_MAX + 1);

    logic [CW-1:0] cnt;
    logic          hunt;
    logic          accept;

    // in hunt any edge locks; otherwise only late edges count as mid-cell
    assign accept = edge_i && (hunt || (cnt >= CW'(GAP_MIN)));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            hunt   <= 1'b1;
            bit_o  <= '0;
            lost_o <= 1'b0;
        end else begin
            bit_o.stb <= 1'b0;
            lost_o    <= 1'b0;
            if (accept) begin
                cnt  <= '0;
                hunt <= 1'b0;
            end else if (hunt) begin
                cnt <= '0;
            end else if (cnt == CW'(GAP_MAX)) begin
                cnt    <= '0;
                hunt   <= 1'b1;
                lost_o <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
            if (!hunt && !accept && (cnt == CW'(SAMPLE_DLY - 1))) begin
                bit_o.stb <= 1'b1;
                bit_o.val <= lvl;
            end
        end
    end

endmodule

// File: rtl/mcr_deframe.sv
module mcr_deframe
    import mcr_pkg::*;
#(
    parameter int unsigned WORD_W   = WORD_W_DEF,
    parameter int unsigned ZERO_MIN = ZERO_MIN_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  rxbit_t            bit_i,
    input  logic              lost_i,
    output logic [WORD_W-1:0] word_o,
    output logic              vld_o
);
    localparam int unsigned ZW = $clog2(ZERO_MIN + 1);
    localparam int unsigned BW = $clog2(WORD_W);

    fr_state_e         state;
    logic [ZW-1:0]     zrun;
    logic [BW-1:0]     bcnt;
    logic [WORD_W-1:0] sh;
    logic [WORD_W-1:0] sh_nxt;

    assign sh_nxt = {sh[WORD_W-2:0], bit_i.val};

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= FR_SEEK;
            zrun   <= '0;
            bcnt   <= '0;
            sh     <= '0;
            word_o <= '0;
            vld_o  <= 1'b0;
        end else begin
            vld_o <= 1'b0;
            if (lost_i) begin
                state <= FR_SEEK;
                zrun  <= '0;
            end else if (bit_i.stb) begin
                case (state)
                    FR_SEEK: begin
                        if (!bit_i.val) begin
                            if (zrun != ZW'(ZERO_MIN)) begin
                                zrun <= zrun + 1'b1;
                            end
                        end else begin
                            if (zrun == ZW'(ZERO_MIN)) begin
                                state <= FR_COLLECT;
                                bcnt  <= '0;
                            end
                            zrun <= '0;
                        end
                    end
                    FR_COLLECT: begin
                        sh   <= sh_nxt;
                        bcnt <= bcnt + 1'b1;
                        zrun <= '0;
                        if (bcnt == BW'(WORD_W - 1)) begin
                            word_o <= sh_nxt;
                            vld_o  <= 1'b1;
                            state  <= FR_SEEK;
                        end
                    end
                    default: state <= FR_SEEK;
                endcase
            end
        end
    end

endmodule

// File: rtl/mcr_rx.sv
module mcr_rx
    import mcr_pkg::*;
#(
    parameter int unsigned WORD_W     = WORD_W_DEF,
    parameter int unsigned ZERO_MIN   = ZERO_MIN_DEF,
    parameter int unsigned GAP_MIN    = GAP_MIN_DEF,
    parameter int unsigned GAP_MAX    = GAP_MAX_DEF,
    parameter int unsigned SAMPLE_DLY = SAMPLE_DLY_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_in,
    output logic              bit_data,
    output logic              bit_stb,
    output logic [WORD_W-1:0] word_data,
    output logic              word_vld
);
    logic   lvl;
    logic   edge_w;
    rxbit_t rbit;
    logic   lost;

    mcr_sync #(
        .IDLE_LVL (1'b1)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .din    (line_in),
        .lvl    (lvl),
        .edge_o (edge_w)
    );

    mcr_phase #(
        .GAP_MIN    (GAP_MIN),
        .GAP_MAX    (GAP_MAX),
        .SAMPLE_DLY (SAMPLE_DLY)
    ) u_phase (
        .clk    (clk),
        .rst    (rst),
        .lvl    (lvl),
        .edge_i (edge_w),
        .bit_o  (rbit),
        .lost_o (lost)
    );

    mcr_deframe #(
        .WORD_W   (WORD_W),
        .ZERO_MIN (ZERO_MIN)
    ) u_deframe (
        .clk    (clk),
        .rst    (rst),
        .bit_i  (rbit),
        .lost_i (lost),
        .word_o (word_data),
        .vld_o  (word_vld)
    );

    assign bit_data = rbit.val;
    assign bit_stb  = rbit.stb;

endmodule

// File: rtl/mcr_rx_chk.sv
module mcr_rx_chk #(
    parameter int unsigned WORD_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bit_stb,
    input logic              word_vld,
    input logic [WORD_W-1:0] word_data,
    input logic              lost
);
    // R6
    vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        word_vld |=> !word_vld);

    // R6
    vld_after_stb_chk: assert property (@(posedge clk) disable iff (rst)
        word_vld |-> $past(bit_stb));

    // R6
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !word_vld |-> $stable(word_data));

    // R3
    stb_gap_chk: assert property (@(posedge clk) disable iff (rst)
        bit_stb |=> !bit_stb);

    // R8
    lost_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        lost |-> (!bit_stb && !word_vld));

endmodule

bind mcr_rx mcr_rx_chk #(
    .WORD_W (WORD_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_stb   (bit_stb),
    .word_vld  (word_vld),
    .word_data (word_data),
    .lost      (lost)
);

// File: tb/sim_mcr_rx.sv
module sim_mcr_rx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_in = 1'b1;
    logic        bit_data;
    logic        bit_stb;
    logic [15:0] word_data;
    logic        word_vld;

    always #4 clk = ~clk;

    mcr_rx u0 (
        .clk       (clk),
        .rst       (rst),
        .line_in   (line_in),
        .bit_data  (bit_data),
        .bit_stb   (bit_stb),
        .word_data (word_data),
        .word_vld  (word_vld)
    );

    int          n_chk  = 0;
    int          n_fail = 0;
    logic [15:0] word_q[$];
    logic        bit_q[$];
    logic        prev_stb = 1'b0;
    bit          done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: pops expected bits and words as the design produces them
    always @(negedge clk) begin
        if (!rst) begin
            if (bit_stb) begin
                if (bit_q.size() == 0) begin
                    chk(1'b0, "R3", "strobe with nothing sent", 32'd1, 32'd0);
                end else begin
                    logic e;
                    e = bit_q.pop_front();
                    chk(bit_data == e, "R3", "recovered bit", {31'd0, bit_data}, {31'd0, e});
                end
            end
            if (word_vld) begin
                chk(prev_stb, "R6", "valid one cycle after last strobe", {31'd0, prev_stb}, 32'd1);
                if (word_q.size() == 0) begin
                    chk(1'b0, "R4", "unexpected word", {16'd0, word_data}, 32'd0);
                end else begin
                    logic [15:0] w;
                    w = word_q.pop_front();
                    chk(word_data == w, "R5", "word value", {16'd0, word_data}, {16'd0, w});
                end
            end
            prev_stb = bit_stb;
        end
    end

    // driver: one bit cell of p clocks, inverse first half, bit second half (R2)
    task automatic send_bit(input logic b, input int p);
        bit_q.push_back(b);
        repeat (p / 2) begin
            line_in = ~b;
            @(negedge clk);
        end
        repeat (p - p / 2) begin
            line_in = b;
            @(negedge clk);
        end
    endtask

    task automatic send_frame(input int nz, input logic [15:0] d, input int p, input bit expect_word);
        if (expect_word) word_q.push_back(d);
        for (int i = 0; i < nz; i++) send_bit(1'b0, p);
        send_bit(1'b1, p);
        for (int i = 15; i >= 0; i--) send_bit(d[i], p);
    endtask

    task automatic idle(input int n);
        line_in = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R1", "watchdog expired", 32'd0, 32'd1);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(!word_vld && !bit_stb, "R1", "strobes low in reset", {30'd0, word_vld, bit_stb}, 32'd0);
        chk(word_data == 16'd0, "R1", "word cleared in reset", {16'd0, word_data}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!word_vld && !bit_stb && word_data == 16'd0, "R1", "first cycle after reset",
            {14'd0, word_vld, bit_stb, word_data}, 32'd0);
        idle(10);

        // R4 R5: long zero run, mixed data
        send_frame(31, 16'hA5C3, 8, 1'b1);
        // R4: exactly 18 zeros accepted, R5 MSB/LSB positions
        send_frame(18, 16'h8001, 8, 1'b1);
        // R4: only 17 zeros, start rejected
        send_frame(17, 16'hFFFF, 8, 1'b0);
        // R4: 18 zeros after ones, all-zero data
        send_frame(18, 16'h0000, 8, 1'b1);
        // R9: data zeros must not count; only 2 fresh zeros here
        send_frame(2, 16'hFFFF, 8, 1'b0);
        idle(20);

        // R7: bit period tolerance
        send_frame(18, 16'h1234, 7, 1'b1);
        idle(20);
        send_frame(20, 16'hBEEF, 12, 1'b1);
        idle(20);
        send_frame(25, 16'h0F0F, 10, 1'b1);
        idle(20);

        // R8: word cut off by an idle line is dropped
        for (int i = 0; i < 20; i++) send_bit(1'b0, 8);
        send_bit(1'b1, 8);
        send_bit(1'b1, 8); send_bit(1'b0, 8); send_bit(1'b1, 8); send_bit(1'b1, 8);
        send_bit(1'b0, 8); send_bit(1'b0, 8); send_bit(1'b1, 8); send_bit(1'b0, 8);
        idle(25);
        chk(bit_q.size() == 0, "R8", "no strobes while idle / bits consumed", bit_q.size(), 32'd0);
        send_frame(18, 16'hC001, 8, 1'b1);
        idle(25);

        // R8: zero count cleared by loss (10 + 8 zeros must not start a word)
        for (int i = 0; i < 10; i++) send_bit(1'b0, 8);
        idle(25);
        send_frame(8, 16'hFFFF, 8, 1'b0);
        idle(25);
        send_frame(19, 16'h6D2B, 8, 1'b1);
        idle(30);

        chk(word_q.size() == 0, "R4", "expected words all delivered", word_q.size(), 32'd0);
        chk(bit_q.size() == 0, "R3", "every sent bit strobed", bit_q.size(), 32'd0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule